// File: doc/BRIEF.md
# Packet-Filter Integer Execute Stage

This block is the arithmetic execute stage of a 64-bit packet-filter style processor. Each cycle it may accept one 64-bit instruction word along with the current values of the destination and source registers. It decodes the word, computes the arithmetic result, and registers it. One cycle later it presents the result, the destination register index, a write-enable for the register file and an illegal-instruction flag.

The same set of operations runs in two classes. One class works on 32-bit operands and the other on 64-bit operands. An opcode bit picks the second operand: either a register value or the 32-bit immediate carried in the instruction. The register file, memory access and control flow belong to neighbouring blocks.

Instruction word, from bit 63 down to bit 0: immediate `[63:32]`, offset `[31:16]` (not used here), source index `[15:12]`, destination index `[11:8]`, opcode `[7:0]`. Within the opcode, bits `[2:0]` hold the class, bit 3 is the operand select, and bits `[7:4]` hold the operation.

Top module: `alu_exec`

## Requirements
- R1: A class value of 3'd4 selects 32-bit mode and 3'd7 selects 64-bit mode. Any other class sets `res_illegal`. `res_dst` always carries instruction bits [11:8].
- R2: When opcode bit 3 is 1, the second operand is `src_val`. When it is 0, the second operand is the immediate (bits [63:32]), sign-extended to 64 bits in 64-bit mode.
- R3: In 32-bit mode, both operands are cut to their low 32 bits and the result is zero-extended to 64 bits. Two exceptions apply: modulo by zero (R7) and byte-order conversion (R9).
- R4: The operation nibble values are: add 0, sub 1, mul 2 (low 64 bits of the product), or 4, and 5, xor 10, and move 11. Move passes the second operand through.
- R5: The operation nibbles for shifts are: left 6, logical right 7 (zero fill) and arithmetic right 12 (sign fill from bit 31 or bit 63). The shift amount is the second operand masked to 5 bits in 32-bit mode and to 6 bits in 64-bit mode.
- R6: Nibble 3 is an unsigned divide and nibble 9 is an unsigned remainder. Division by zero yields 0.
- R7: Remainder by zero returns the full 64-bit `dst_val` unchanged, in both modes.
- R8: Nibble 8 negates the destination operand (two's complement) and ignores the second operand.
- R9: Nibble 13 converts byte order on `dst_val`. The immediate gives the width: 16, 32 or 64. With opcode bit 3 at 0, the low width bits are kept and zero-extended. With bit 3 at 1, the bytes of the low width bits are reversed and then zero-extended. Any other width is illegal. The result does not depend on the class.
- R10: Nibbles 14 and 15 set `res_illegal`. An illegal instruction gives a result of 0 and `res_wen` low.
- R11: `res_valid` follows `in_valid` one cycle later. `res_wen` equals `res_valid` and not `res_illegal`. Whenever `res_valid` is low, `res_wen` and `res_illegal` are low. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 64 | Instruction word |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Current source register value |
| res_valid | output | 1 | Result present |
| res_data | output | 64 | Result value |
| res_dst | output | 4 | Destination register index |
| res_wen | output | 1 | Write destination register |
| res_illegal | output | 1 | Unsupported encoding seen |

## Verification
The assertions assume only that `in_valid`, `insn` and the operand values are free of unknowns whenever they are sampled at a clock edge. They place no constraint on how encodings are ordered or mixed, so any stream of instructions is legal input. The bench always drives every input from a defined value. Its random stream is weighted toward the two legal classes while still producing illegal classes, illegal nibbles and illegal byte-order widths. Directed cases cover zero divisors, shift amounts beyond the mask, sign-extended immediates and every conversion width.

// File: rtl/alu_exec.sv
module alu_exec #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] insn,
  input  logic [W-1:0] dst_val,
  input  logic [W-1:0] src_val,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic [3:0]   res_dst,
  output logic         res_wen,
  output logic         res_illegal
);
  localparam int H = W / 2;

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2, OP_DIV = 4'd3,
                         OP_OR  = 4'd4, OP_AND = 4'd5, OP_LSH = 4'd6, OP_RSH = 4'd7,
                         OP_NEG = 4'd8, OP_MOD = 4'd9, OP_XOR = 4'd10, OP_MOV = 4'd11,
                         OP_ARS = 4'd12, OP_END = 4'd13;

  wire [2:0]   cls     = insn[2:0];
  wire         use_reg = insn[3];
  wire [3:0]   op      = insn[7:4];
  wire [H-1:0] imm     = insn[W-1:H];
  wire         wide    = (cls == 3'd7);
  wire         cls_ok  = (cls == 3'd4) || wide;

  wire [W-1:0] b_raw = use_reg ? src_val : {{H{imm[H-1]}}, imm};
  wire [W-1:0] a     = wide ? dst_val : {{H{1'b0}}, dst_val[H-1:0]};
  wire [W-1:0] b     = wide ? b_raw   : {{H{1'b0}}, b_raw[H-1:0]};
  wire [5:0]   sh    = wide ? b[5:0]  : {1'b0, b[4:0]};
  wire         bzero = (b == '0);

  wire         ew16  = (imm == 32'd16);
  wire         ew32  = (imm == 32'd32);
  wire         ew64  = (imm == 32'd64);
  wire         ew_ok = ew16 | ew32 | ew64;

  wire [W-1:0] ars64 = W'($signed(a) >>> sh);
  wire [H-1:0] ars32 = H'($signed(a[H-1:0]) >>> sh[4:0]);

  logic [W-1:0] swapped;
  always_comb begin
    swapped = '0;
    if (ew16)      swapped[15:0] = {dst_val[7:0], dst_val[15:8]};
    else if (ew32) swapped[31:0] = {dst_val[7:0], dst_val[15:8], dst_val[23:16], dst_val[31:24]};
    else
      for (int i = 0; i < W / 8; i++)
        swapped[8*i +: 8] = dst_val[W-8-8*i +: 8];
  end

  logic [W-1:0] kept;
  always_comb begin
    kept = dst_val;
    if (ew16)      kept = {{(W-16){1'b0}}, dst_val[15:0]};
    else if (ew32) kept = {{(W-32){1'b0}}, dst_val[31:0]};
  end

  logic [W-1:0] r;
  always_comb begin
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = a * b;
      OP_DIV:  r = bzero ? '0 : a / b;
      OP_OR:   r = a | b;
      OP_AND:  r = a & b;
      OP_LSH:  r = a << sh;
      OP_RSH:  r = a >> sh;
      OP_NEG:  r = '0 - a;
      OP_MOD:  r = bzero ? dst_val : a % b;
      OP_XOR:  r = a ^ b;
      OP_MOV:  r = b;
      OP_ARS:  r = wide ? ars64 : {{H{1'b0}}, ars32};
      OP_END:  r = use_reg ? swapped : kept;
      default: r = '0;
    endcase
  end

  wire         illegal = !cls_ok || (op > OP_END) || (op == OP_END && !ew_ok);
  wire         keep_w  = wide || op == OP_END || (op == OP_MOD && bzero);
  wire [W-1:0] result  = illegal ? '0 : (keep_w ? r : {{H{1'b0}}, r[H-1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_dst     <= '0;
      res_illegal <= 1'b0;
    end else begin
      res_valid   <= in_valid;
      res_data    <= in_valid ? result : '0;
      res_dst     <= in_valid ? insn[11:8] : '0;
      res_illegal <= in_valid && illegal;
    end
  end

  assign res_wen = res_valid && !res_illegal;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_wen && !res_illegal));
  a_r1_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls != 3'd4 && cls != 3'd7) |=> (res_illegal && !res_wen));
  a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OP_END) |=> (res_illegal && res_data == '0));
  a_r3_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == 3'd4 && op != OP_MOD && op != OP_END) |=> (res_data[W-1:H] == '0));
  a_r1_dst_index: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_dst == $past(insn[11:8])));
endmodule

// File: tb/alu_exec_bench.sv
module alu_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] insn = '0, dst_val = '0, src_val = '0;
  logic        res_valid, res_wen, res_illegal;
  logic [63:0] res_data;
  logic [3:0]  res_dst;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_exec u_alu_exec (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .dst_val(dst_val), .src_val(src_val), .res_valid(res_valid), .res_data(res_data),
    .res_dst(res_dst), .res_wen(res_wen), .res_illegal(res_illegal));

  function automatic logic [64:0] model(logic [63:0] i, logic [63:0] d, logic [63:0] s);
    logic [7:0] oc = i[7:0];
    logic [31:0] im = i[63:32];
    logic w64 = oc[2:0] == 3'd7;
    logic [63:0] x, y, o;
    logic [5:0] n;
    int wb;
    if (oc[2:0] != 3'd4 && oc[2:0] != 3'd7) return {1'b1, 64'd0};
    if (oc[7:4] > 4'd13) return {1'b1, 64'd0};
    if (oc[7:4] == 4'd13) begin
      if (im == 32'd16) wb = 2; else if (im == 32'd32) wb = 4;
      else if (im == 32'd64) wb = 8; else return {1'b1, 64'd0};
      o = '0;
      for (int k = 0; k < wb; k++)
        o[8*k +: 8] = oc[3] ? d[8*(wb-1-k) +: 8] : d[8*k +: 8];
      return {1'b0, o};
    end
    y = oc[3] ? s : {{32{im[31]}}, im};
    x = d;
    if (!w64) begin x = {32'd0, d[31:0]}; y = {32'd0, y[31:0]}; end
    n = w64 ? y[5:0] : {1'b0, y[4:0]};
    case (oc[7:4])
      4'd0: o = x + y;
      4'd1: o = x - y;
      4'd2: o = x * y;
      4'd3: o = (y == 0) ? 64'd0 : x / y;
      4'd4: o = x | y;
      4'd5: o = x & y;
      4'd6: o = x << n;
      4'd7: o = x >> n;
      4'd8: o = -x;
      4'd9: begin if (y == 0) return {1'b0, d}; o = x % y; end
      4'd10: o = x ^ y;
      4'd11: o = y;
      default: begin
        o = x >> n;
        if (w64 ? x[63] : x[31])
          for (int k = 0; k < 64; k++)
            if (k >= (w64 ? 64 : 32) - n) o[k] = 1'b1;
      end
    endcase
    if (!w64) o = {32'd0, o[31:0]};
    return {1'b0, o};
  endfunction

  function automatic string tag_of(logic [63:0] i);
    if (i[2:0] != 3'd4 && i[2:0] != 3'd7) return "R1";
    case (i[7:4])
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd10, 4'd11: return "R4";
      4'd6, 4'd7, 4'd12: return "R5";
      4'd3: return "R6";
      4'd9: return "R7";
      4'd8: return "R8";
      4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string t, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic run(logic [63:0] i, logic [63:0] d, logic [63:0] s);
    logic [64:0] e = model(i, d, s);
    string t = tag_of(i);
    @(negedge clk);
    insn = i; dst_val = d; src_val = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(t, res_data, e[63:0]);
    check({t, " illegal"}, 64'(res_illegal), 64'(e[64]));
    check("R11 wen", 64'(res_wen), 64'(!e[64]));
    check("R11 valid", 64'(res_valid), 64'd1);
    check("R1 dst", 64'(res_dst), 64'(i[11:8]));
  endtask

  function automatic logic [63:0] mk(logic [31:0] im, logic [3:0] op, logic rg, logic [2:0] c);
    return {im, 16'h0, 4'h2, 4'h5, op, rg, c};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R11 reset valid", 64'(res_valid), 64'd0);
    check("R11 reset data", res_data, 64'd0);
    rst_n = 1'b1;
    run(mk(32'd5, 4'd0, 1'b1, 3'd7), 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    run(mk(32'd5, 4'd0, 1'b1, 3'd4), 64'h1234_5678_FFFF_FFFF, 64'd2);   // R3 wrap
    run(mk(32'hFFFF_FFFE, 4'd0, 1'b0, 3'd7), 64'd10, 64'd0);           // R2 sign-extend
    run(mk(32'hFFFF_FFFE, 4'd11, 1'b0, 3'd4), 64'd10, 64'd0);          // R2 narrow imm
    run(mk(32'd0, 4'd3, 1'b1, 3'd7), 64'd99, 64'd0);                   // R6 div zero
    run(mk(32'd0, 4'd9, 1'b1, 3'd4), 64'hDEAD_BEEF_0000_0007, 64'd0);  // R7 mod zero
    run(mk(32'd0, 4'd9, 1'b1, 3'd4), 64'h1_0000_0007, 64'h1_0000_0000); // R7 narrow divisor zero
    run(mk(32'd0, 4'd12, 1'b1, 3'd4), 64'h8000_0000, 64'd35);          // R5 mask 5 bits
    run(mk(32'd0, 4'd12, 1'b1, 3'd7), 64'h8000_0000_0000_0000, 64'd68); // R5 mask 6 bits
    run(mk(32'd0, 4'd7, 1'b1, 3'd7), 64'h8000_0000_0000_0000, 64'd4);  // R5 zero fill
    run(mk(32'd0, 4'd8, 1'b1, 3'd4), 64'd1, 64'd77);                   // R8
    run(mk(32'd16, 4'd13, 1'b1, 3'd4), 64'h1122_3344_5566_7788, 64'd0); // R9
    run(mk(32'd32, 4'd13, 1'b0, 3'd7), 64'h1122_3344_5566_7788, 64'd0); // R9
    run(mk(32'd64, 4'd13, 1'b1, 3'd4), 64'h1122_3344_5566_7788, 64'd0); // R9
    run(mk(32'd8, 4'd13, 1'b1, 3'd7), 64'h1, 64'd0);                   // R9 bad width
    run(mk(32'd1, 4'd14, 1'b1, 3'd7), 64'h1, 64'd1);                   // R10
    run(mk(32'd1, 4'd0, 1'b1, 3'd5), 64'h1, 64'd1);                    // R1 bad class
    @(negedge clk);
    check("R11 valid drop", 64'(res_valid), 64'd0);
    check("R11 wen idle", 64'(res_wen), 64'd0);
    for (int k = 0; k < 400; k++) begin
      logic [7:0] oc = 8'($urandom);
      logic [31:0] im = $urandom;
      if ($urandom_range(9) != 0) oc[2:0] = $urandom_range(1) ? 3'd7 : 3'd4;
      if (oc[7:4] == 4'd13 && $urandom_range(3) != 0) im = 32'd16 << $urandom_range(2);
      run({im, 16'($urandom), 8'($urandom), oc},
          {32'($urandom), 32'($urandom)},
          $urandom_range(7) == 0 ? 64'd0 : {32'($urandom), 32'($urandom)});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11: watchdog actual hang expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule